// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Store Queue

This block is a direct-mapped data cache with one-word lines. It sits between a processor load/store port and a word-wide memory port that is slower than the processor. Loads that find their line present answer in the same cycle. Loads that miss fetch one word from memory, install it in the line, and then answer. Stores update a present line. Every store, whether or not its line is present, is also placed in a small queue of posted writes, and that queue drains to memory by itself. The processor therefore waits for memory only when the queue is full or a load miss has to read.

The processor holds a request (`cpu_req` with `cpu_we`, `cpu_addr` and `cpu_wdata`) until a cycle in which `cpu_stall` is low. The request is accepted at the rising edge at the end of that cycle. For a load, `cpu_rvalid` and `cpu_rdata` are valid in that same cycle. The memory side runs one transaction at a time. `mem_req` rises with the address, the direction and the write data, all of which stay stable until the memory pulses `mem_ack` for one cycle. For a read, `mem_rdata` is valid with that pulse.

Top module: `wt_cache_top`

## Requirements
- R1: Address bits 31..12 form the tag and bits 11..2 form the line index, which gives 1024 lines. Bits 1..0 are ignored, so addresses that differ only there share a line. Addresses with the same index and different tags evict each other.
- R2: After a synchronous active-high reset, every line is empty and the store queue is empty. `mem_req` is low in the first cycle after reset. The first load to any address then misses, even when the tag bits are zero.
- R3: A load to a present line with a matching tag completes in the cycle it is presented: `cpu_stall` is low, `cpu_rvalid` is high, `cpu_rdata` holds the line data, and no memory transaction takes place.
- R4: A load miss holds `cpu_stall` high and issues exactly one memory read of its word address. It writes the returned word and tag into the line. The load completes in the cycle after the acknowledge.
- R5: A store to a present line with a matching tag updates the line data. A later load to that address returns the new value without a memory read.
- R6: A store miss leaves the cache unchanged (no allocation). A later load to that address misses, reads memory once and returns the stored value.
- R7: Every accepted store reaches memory exactly once, as a full word at its word address with bits 1..0 of `mem_addr` zero. Stores reach memory in the order in which they were accepted.
- R8: While the store queue holds fewer than 4 entries, a store is accepted without stall. When 4 stores are outstanding, a further store stalls until one entry has been acknowledged by memory.
- R9: A load miss whose word address matches a queued store waits until no matching entry remains in the queue. It then reads memory and returns the most recent stored value, never stale data.
- R10: A transaction in progress is never interrupted. At the next idle point, a load miss with no matching queued store takes the port before the remaining queued stores. Otherwise queued stores use the port.
- R11: Only one memory transaction is outstanding at a time. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`, and `mem_req` is low in the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor access request, held until not stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_stall | output | 1 | Request cannot complete in this cycle |
| cpu_rvalid | output | 1 | Load data valid in this cycle |
| cpu_rdata | output | 32 | Load data |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle completion pulse from memory |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
A corrupted valid bit or tag shows up at the ports on the very next load to that index. The load either returns without the memory read the bench expects, or it spends an extra read where a hit was expected. A wrong queue pointer or a missed match shows up as a reordered or missing memory write when the queue drains, or as a load that returns an older value than the last store. Both appear within a few memory latencies. The bench keeps its own record of line contents, of current values and of pending writes, and compares each load result, each read count and each memory write against that record.

// File: rtl/wtc_pkg.sv
`timescale 1ns/1ps
package wtc_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int OFS_W   = 2;
    localparam int WADDR_W = ADDR_W - OFS_W;

    typedef logic [WADDR_W-1:0] waddr_t;
    typedef logic [DATA_W-1:0]  word_t;

    typedef struct packed {
        waddr_t waddr;
        word_t  data;
    } post_entry_t;

    typedef enum logic [1:0] {
        PORT_IDLE,
        PORT_WRITE,
        PORT_READ
    } port_state_e;

    function automatic waddr_t word_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFS_W];
    endfunction
endpackage

// File: rtl/wtc_line_store.sv
`timescale 1ns/1ps
module wtc_line_store
    import wtc_pkg::*;
#(
    parameter int INDEX_W = 10,
    parameter int TAG_W   = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INDEX_W-1:0] lk_index,
    input  logic [TAG_W-1:0]   lk_tag,
    output logic               lk_hit,
    output word_t              lk_data,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_index,
    input  logic [TAG_W-1:0]   wr_tag,
    input  word_t              wr_data
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0] present_q;
    logic [TAG_W-1:0] tag_mem  [LINES];
    word_t            data_mem [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            present_q <= '0;
        end else if (wr_en) begin
            present_q[wr_index] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_index]  <= wr_tag;
            data_mem[wr_index] <= wr_data;
        end
    end

    assign lk_hit  = present_q[lk_index] && (tag_mem[lk_index] == lk_tag);
    assign lk_data = data_mem[lk_index];
endmodule

// File: rtl/wtc_post_buf.sv
`timescale 1ns/1ps
module wtc_post_buf
    import wtc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  post_entry_t                push_entry,
    input  logic                       pop,
    output post_entry_t                head,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count,
    input  waddr_t                     probe_waddr,
    output logic                       probe_match
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    post_entry_t       slots [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_entry;
    end

    always_comb begin
        probe_match = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            int age;
            age = (i >= int'(rd_ptr)) ? i - int'(rd_ptr) : i + DEPTH - int'(rd_ptr);
            if ((age < int'(count_q)) && (slots[i].waddr == probe_waddr))
                probe_match = 1'b1;
        end
    end

    assign head  = slots[rd_ptr];
    assign empty = (count_q == '0);
    assign full  = (count_q == CNT_W'(DEPTH));
    assign count = count_q;
endmodule

// File: rtl/wtc_port_arb.sv
`timescale 1ns/1ps
module wtc_port_arb
    import wtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_empty,
    input  post_entry_t       wb_head,
    output logic              wb_pop,
    input  logic              miss_pending,
    input  logic              miss_conflict,
    input  waddr_t            miss_waddr,
    output logic              fill_en,
    output waddr_t            fill_waddr,
    output word_t             fill_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output word_t             mem_wdata,
    input  logic              mem_ack,
    input  word_t             mem_rdata
);
    port_state_e state_q;
    waddr_t      rd_waddr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= PORT_IDLE;
            rd_waddr_q <= '0;
        end else begin
            case (state_q)
                PORT_IDLE: begin
                    if (miss_pending && !miss_conflict) begin
                        state_q    <= PORT_READ;
                        rd_waddr_q <= miss_waddr;
                    end else if (!wb_empty) begin
                        state_q <= PORT_WRITE;
                    end
                end
                PORT_WRITE: if (mem_ack) state_q <= PORT_IDLE;
                PORT_READ:  if (mem_ack) state_q <= PORT_IDLE;
                default:    state_q <= PORT_IDLE;
            endcase
        end
    end

    assign mem_req    = (state_q != PORT_IDLE);
    assign mem_we     = (state_q == PORT_WRITE);
    assign mem_addr   = {(mem_we ? wb_head.waddr : rd_waddr_q), {OFS_W{1'b0}}};
    assign mem_wdata  = wb_head.data;
    assign wb_pop     = (state_q == PORT_WRITE) && mem_ack;
    assign fill_en    = (state_q == PORT_READ) && mem_ack;
    assign fill_waddr = rd_waddr_q;
    assign fill_data  = mem_rdata;
endmodule

// File: rtl/wt_cache_top.sv
`timescale 1ns/1ps
module wt_cache_top
    import wtc_pkg::*;
#(
    parameter int INDEX_W  = 10,
    parameter int WB_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_stall,
    output logic        cpu_rvalid,
    output logic [31:0] cpu_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - INDEX_W - OFS_W;
    localparam int CNT_W = $clog2(WB_DEPTH + 1);

    waddr_t             req_waddr;
    logic [INDEX_W-1:0] req_index;
    logic [TAG_W-1:0]   req_tag;
    logic               lk_hit;
    word_t              lk_data;
    logic               is_load, store_go, miss_pending;
    logic               wb_full, wb_empty, wb_pop, wb_match;
    logic [CNT_W-1:0]   wb_count;
    post_entry_t        wb_head, wb_in;
    logic               fill_en;
    waddr_t             fill_waddr;
    word_t              fill_data;
    logic               wr_en;
    logic [INDEX_W-1:0] wr_index;
    logic [TAG_W-1:0]   wr_tag;
    word_t              wr_data;
    logic               unused_ofs;

    assign req_waddr  = word_of(cpu_addr);
    assign req_index  = req_waddr[INDEX_W-1:0];
    assign req_tag    = req_waddr[WADDR_W-1 -: TAG_W];
    assign unused_ofs = ^cpu_addr[OFS_W-1:0];

    assign is_load      = cpu_req && !cpu_we;
    assign store_go     = cpu_req && cpu_we && !wb_full;
    assign miss_pending = is_load && !lk_hit;

    assign cpu_stall  = cpu_req && (cpu_we ? wb_full : !lk_hit);
    assign cpu_rvalid = is_load && lk_hit;
    assign cpu_rdata  = lk_data;

    assign wb_in.waddr = req_waddr;
    assign wb_in.data  = cpu_wdata;

    always_comb begin
        if (fill_en) begin
            wr_en    = 1'b1;
            wr_index = fill_waddr[INDEX_W-1:0];
            wr_tag   = fill_waddr[WADDR_W-1 -: TAG_W];
            wr_data  = fill_data;
        end else begin
            wr_en    = store_go && lk_hit;
            wr_index = req_index;
            wr_tag   = req_tag;
            wr_data  = cpu_wdata;
        end
    end

    wtc_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) lines_i (
        .clk      (clk),
        .rst      (rst),
        .lk_index (req_index),
        .lk_tag   (req_tag),
        .lk_hit   (lk_hit),
        .lk_data  (lk_data),
        .wr_en    (wr_en),
        .wr_index (wr_index),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data)
    );

    wtc_post_buf #(.DEPTH(WB_DEPTH)) queue_i (
        .clk         (clk),
        .rst         (rst),
        .push        (store_go),
        .push_entry  (wb_in),
        .pop         (wb_pop),
        .head        (wb_head),
        .empty       (wb_empty),
        .full        (wb_full),
        .count       (wb_count),
        .probe_waddr (req_waddr),
        .probe_match (wb_match)
    );

    wtc_port_arb arb_i (
        .clk           (clk),
        .rst           (rst),
        .wb_empty      (wb_empty),
        .wb_head       (wb_head),
        .wb_pop        (wb_pop),
        .miss_pending  (miss_pending),
        .miss_conflict (wb_match),
        .miss_waddr    (req_waddr),
        .fill_en       (fill_en),
        .fill_waddr    (fill_waddr),
        .fill_data     (fill_data),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_ack       (mem_ack),
        .mem_rdata     (mem_rdata)
    );
endmodule

// File: rtl/wtc_chk.sv
`timescale 1ns/1ps
module wtc_chk #(
    parameter int WB_DEPTH = 4,
    parameter int CNT_W    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_req,
    input logic             cpu_we,
    input logic             cpu_stall,
    input logic             cpu_rvalid,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [31:0]      mem_addr,
    input logic [CNT_W-1:0] wb_count
);
    // R2
    reset_idle_chk: assert property (@(posedge clk) rst |=> (!mem_req && wb_count == '0));

    // R3
    rvalid_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_rvalid |-> (cpu_req && !cpu_we && !cpu_stall));

    // R4
    read_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> cpu_stall);

    // R7
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R8
    store_room_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && (int'(wb_count) < WB_DEPTH)) |-> !cpu_stall);

    // R8
    queue_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(wb_count) <= WB_DEPTH);

    // R11
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11
    one_xact_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> !mem_req);
endmodule

bind wt_cache_top wtc_chk #(.WB_DEPTH(WB_DEPTH), .CNT_W($clog2(WB_DEPTH + 1))) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_stall  (cpu_stall),
    .cpu_rvalid (cpu_rvalid),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .wb_count   (wb_count)
);

// File: tb/wt_cache_top_tb_top.sv
`timescale 1ns/1ps
module wt_cache_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_stall, cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    wt_cache_top dut_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #10 clk = ~clk;

    typedef struct { logic [29:0] wa; logic [31:0] d; } wr_t;
    wr_t         exp_q[$];
    logic [31:0] bmem    [logic [29:0]];
    logic [31:0] ref_mem [logic [29:0]];
    bit          mv [1024];
    logic [19:0] mt [1024];
    int checks = 0, errors = 0, rd_count = 0, lat_cfg = 0;
    bit done = 0, log_on = 0;
    int log_n = 0;
    logic        log_we [8];
    logic [31:0] log_addr [8];

    function automatic logic [31:0] dflt(input logic [29:0] wa);
        return {wa, 2'b01} ^ 32'hA5A5_0000;
    endfunction

    function automatic logic [31:0] ref_read(input logic [29:0] wa);
        return ref_mem.exists(wa) ? ref_mem[wa] : dflt(wa);
    endfunction

    function automatic logic [31:0] mk_addr(input int tag, input int idx, input int ofs);
        return {tag[19:0], idx[9:0], ofs[1:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model: variable latency, one-cycle acknowledge
    initial begin
        int wcnt = 0, target = 1;
        forever begin
            @(negedge clk);
            if (rst || mem_ack) begin
                mem_ack = 1'b0;
                wcnt = 0;
            end else if (mem_req) begin
                if (wcnt == 0) target = (lat_cfg != 0) ? lat_cfg : 1 + int'($urandom_range(3));
                wcnt++;
                if (wcnt >= target) begin
                    mem_ack = 1'b1;
                    if (log_on && log_n < 8) begin
                        log_we[log_n] = mem_we;
                        log_addr[log_n] = mem_addr;
                        log_n++;
                    end
                    if (mem_we) begin
                        chk(mem_addr[1:0] == 2'b00, "R7", "write alignment", {30'd0, mem_addr[1:0]}, 32'd0);
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R7", "unexpected memory write", mem_addr, 32'hFFFF_FFFF);
                        end else begin
                            wr_t e;
                            e = exp_q.pop_front();
                            chk(mem_addr[31:2] == e.wa, "R7", "write order address", mem_addr, {e.wa, 2'b00});
                            chk(mem_wdata == e.d, "R7", "write data", mem_wdata, e.d);
                        end
                        bmem[mem_addr[31:2]] = mem_wdata;
                    end else begin
                        rd_count++;
                        mem_rdata = bmem.exists(mem_addr[31:2]) ? bmem[mem_addr[31:2]] : dflt(mem_addr[31:2]);
                    end
                end
            end
        end
    end

    task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output bit rv, output int stalls, output int reads);
        int r0;
        @(negedge clk);
        r0 = rd_count;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        stalls = 0;
        #1;
        while (cpu_stall) begin
            @(negedge clk); #1;
            stalls++;
        end
        rd = cpu_rdata;
        rv = cpu_rvalid;
        if (we) begin
            wr_t e;
            e.wa = addr[31:2]; e.d = wd;
            exp_q.push_back(e);
            ref_mem[addr[31:2]] = wd;
        end
        reads = rd_count - r0;
        @(posedge clk); #1;
        cpu_req = 1'b0;
    endtask

    task automatic do_load(input logic [31:0] addr, input string req);
        logic [31:0] rd; bit rv; int st, rdn; bit hit;
        hit = mv[addr[11:2]] && (mt[addr[11:2]] == addr[31:12]);
        access(1'b0, addr, 32'd0, rd, rv, st, rdn);
        chk(rv, req, "load rvalid", {31'd0, rv}, 32'd1);
        chk(rd == ref_read(addr[31:2]), req, "load data", rd, ref_read(addr[31:2]));
        chk(rdn == (hit ? 0 : 1), req, hit ? "reads on hit" : "reads on miss", rdn, hit ? 0 : 1);
        mv[addr[11:2]] = 1'b1;
        mt[addr[11:2]] = addr[31:12];
    endtask

    task automatic do_store(input logic [31:0] addr, input logic [31:0] d, output int st);
        logic [31:0] rd; bit rv; int rdn;
        access(1'b1, addr, d, rd, rv, st, rdn);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (exp_q.size() != 0 || mem_req);
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        foreach (mv[i]) mv[i] = 1'b0;
    endtask

    initial begin
        int st;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R2: reset state
        chk(!mem_req, "R2", "mem_req after reset", {31'd0, mem_req}, 32'd0);
        chk(!cpu_stall, "R2", "stall idle", {31'd0, cpu_stall}, 32'd0);
        do_load(mk_addr(0, 0, 0), "R2");          // tag 0 still misses
        do_load(mk_addr(0, 0, 2), "R1");          // offset bits ignored: hit (R3)
        do_load(mk_addr(0, 0, 1), "R3");
        do_load(mk_addr(1, 0, 0), "R1");          // same index, other tag: miss
        do_load(mk_addr(0, 0, 3), "R4");          // evicted: miss again
        // R5: store hit then load hit
        do_store(mk_addr(0, 0, 0), 32'h1111_2222, st);
        chk(st == 0, "R8", "store stall with room", st, 0);
        do_load(mk_addr(0, 0, 0), "R5");
        wait_idle();
        chk(bmem[30'd0] == 32'h1111_2222, "R7", "memory copy", bmem[30'd0], 32'h1111_2222);
        // R6: store miss, no allocation
        do_store(mk_addr(3, 1, 0), 32'h3333_0001, st);
        wait_idle();
        do_load(mk_addr(3, 1, 0), "R6");
        // R9: load miss right behind matching slow stores
        lat_cfg = 10;
        do_store(mk_addr(2, 2, 0), 32'hAAAA_0001, st);
        do_store(mk_addr(2, 2, 0), 32'hAAAA_0002, st);
        do_load(mk_addr(2, 2, 1), "R9");
        wait_idle();
        // R10: read overtakes queued stores but not the one in flight
        log_n = 0; log_on = 1;
        do_store(mk_addr(4, 3, 0), 32'hB0B0_0001, st);
        do_store(mk_addr(4, 4, 0), 32'hB0B0_0002, st);
        do_load(mk_addr(5, 5, 0), "R10");
        wait_idle();
        log_on = 0;
        chk(log_n == 3, "R10", "transaction count", log_n, 3);
        chk(log_we[0] && log_addr[0] == mk_addr(4, 3, 0), "R10", "first xact", log_addr[0], mk_addr(4, 3, 0));
        chk(!log_we[1] && log_addr[1] == mk_addr(5, 5, 0), "R10", "read second", log_addr[1], mk_addr(5, 5, 0));
        chk(log_we[2] && log_addr[2] == mk_addr(4, 4, 0), "R10", "queued write last", log_addr[2], mk_addr(4, 4, 0));
        // R8: four stores accepted, fifth stalls
        lat_cfg = 12;
        for (int k = 0; k < 4; k++) begin
            do_store(mk_addr(6, 8 + k, 0), 32'hC000_0000 + k, st);
            chk(st == 0, "R8", "store stall below full", st, 0);
        end
        do_store(mk_addr(6, 12, 0), 32'hC000_0004, st);
        chk(st > 0, "R8", "store stall when full", st, 1);
        wait_idle();
        lat_cfg = 0;
        // R1: highest index
        do_load(mk_addr(5, 1023, 0), "R1");
        do_load(mk_addr(5, 1023, 3), "R1");
        // R2: reset empties lines
        do_load(mk_addr(0, 0, 0), "R3");
        wait_idle();
        pulse_reset();
        #1;
        chk(!mem_req, "R2", "mem_req after second reset", {31'd0, mem_req}, 32'd0);
        do_load(mk_addr(0, 0, 0), "R2");
        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            int idx;
            idx = ($urandom_range(7) == 7) ? 1023 : int'($urandom_range(5));
            a = mk_addr(int'($urandom_range(2)), idx, int'($urandom_range(3)));
            if ($urandom_range(9) < 4) do_store(a, $urandom, st);
            else do_load(a, "R9");
        end
        wait_idle();
        chk(exp_q.size() == 0, "R7", "all stores written", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule